// File: doc/BRIEF.md
# Dual-Mode I/O Window Address Translator

This block sits between a big-endian processor bus and a little-endian I/O bus that has 16-bit port addresses. It claims processor accesses that fall inside an 8 MB window and turns each one into a single I/O-bus request. The I/O port address is produced in one of two ways, selected by a mode input. In contiguous mode, the low 16 bits of the window offset are used directly. In sparse mode, every 4 KB processor page carries 32 consecutive I/O ports, which lets page-granular protection isolate small groups of ports.

Write data is byte-reordered on the way out, and read data on the way back, according to the access size. The forwarded request is registered and held with a valid/ready handshake until the I/O side takes it. A read returns to the processor one cycle after the I/O side supplies its data.

Top module: `io_window_xlate`

## Requirements
- R1: A request is claimed (`cpu_req_ready` high) only while the block is idle and `cpu_addr` lies in 0x80000000..0x807FFFFF. A request outside that window is never claimed and creates no I/O request.
- R2: With `sparse_mode` = 0, `io_addr` equals bits 15:0 of the window offset (`cpu_addr` - 0x80000000).
- R3: With `sparse_mode` = 1, `io_addr` is {offset[22:12], offset[4:0]}, which is (offset & 0x1F) | ((offset & 0x7FF000) >> 7).
- R4: Size code 0 (byte) passes all 32 data bits through unchanged, on writes and on reads.
- R5: Size code 1 (half) gives {16'h0000, d[7:0], d[15:8]}, on writes and on reads.
- R6: Size code 2 (word) reverses all four bytes. The reserved code 3 behaves the same as code 2.
- R7: Once `io_req_valid` is raised, it stays high with `io_addr`, `io_wdata`, `io_we` and `io_size` unchanged until a cycle with `io_req_ready` high. No new processor request is claimed while this request or its read is outstanding.
- R8: A read completes with `cpu_rsp_valid` high for exactly one cycle, in the cycle after `io_rsp_valid` was sampled. `cpu_rdata` is reordered using the size captured when the request was claimed.
- R9: After reset, `io_req_valid` and `cpu_rsp_valid` are low.
- R10: A write ends when the I/O side accepts it. It produces no `cpu_rsp_valid`, and the block can claim a new request in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sparse_mode | input | 1 | 0 = contiguous mapping, 1 = sparse mapping |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request claimed this cycle |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | 0 byte, 1 half, 2 word, 3 treated as word |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 32 | Big-endian write data |
| cpu_rsp_valid | output | 1 | Read data valid pulse |
| cpu_rdata | output | 32 | Reordered read data |
| io_req_valid | output | 1 | I/O request pending |
| io_req_ready | input | 1 | I/O side accepts the request |
| io_addr | output | 16 | Translated port address |
| io_we | output | 1 | I/O write flag |
| io_size | output | 2 | Access size forwarded |
| io_wdata | output | 32 | Little-endian write data |
| io_rsp_valid | input | 1 | I/O read data present |
| io_rdata | input | 32 | Little-endian read data |

## Verification
The return-path reordering of a pending read and the arrival of the next processor request can fall in the same cycle. The bench creates this by issuing a word read and, while it waits for data, presenting a new in-window byte request with the other mapping mode. It then checks that the new request stays unclaimed and that the read data comes back reversed as a word rather than passed through as a byte. In the cycle the read completes, the waiting request must be claimed, and its translated address must follow the sparse formula.

// File: rtl/io_xlate_pkg.sv
package io_xlate_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RDW   = 2'd2
    } xlate_state_e;

endpackage

// File: rtl/io_addr_map.sv
module io_addr_map #(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
    parameter int          WIN_BITS  = 23,
    parameter int          IO_W      = 16,
    parameter int          PORT_BITS = 5,
    parameter int          PAGE_LSB  = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sparse,
    output logic              in_win,
    output logic [IO_W-1:0]   io_addr
);
    localparam int PAGE_W = WIN_BITS - PAGE_LSB;

    logic [WIN_BITS-1:0] offset;
    logic [IO_W-1:0]     contig_addr;
    logic [IO_W-1:0]     sparse_addr;

    always_comb begin
        in_win      = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
        offset      = addr[WIN_BITS-1:0];
        contig_addr = offset[IO_W-1:0];
        sparse_addr = IO_W'({offset[WIN_BITS-1 -: PAGE_W], offset[PORT_BITS-1:0]});
        io_addr     = sparse ? sparse_addr : contig_addr;
    end
endmodule

// File: rtl/io_lane_swap.sv
module io_lane_swap
    import io_xlate_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  xfer_size_e        size,
    output logic [DATA_W-1:0] dout
);
    localparam int NB = DATA_W / 8;

    logic [DATA_W-1:0] rev;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign rev[i*8 +: 8] = din[(NB-1-i)*8 +: 8];
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: dout = din;
            SZ_HALF: dout = {{(DATA_W-16){1'b0}}, din[7:0], din[15:8]};
            default: dout = rev;
        endcase
    end
endmodule

// File: rtl/io_window_xlate.sv
module io_window_xlate
    import io_xlate_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          IO_W      = 16,
    parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
    parameter int          WIN_BITS  = 23,
    parameter int          PORT_BITS = 5,
    parameter int          PAGE_LSB  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sparse_mode,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              io_req_valid,
    input  logic              io_req_ready,
    output logic [IO_W-1:0]   io_addr,
    output logic              io_we,
    output logic [1:0]        io_size,
    output logic [DATA_W-1:0] io_wdata,
    input  logic              io_rsp_valid,
    input  logic [DATA_W-1:0] io_rdata
);
    typedef struct packed {
        xlate_state_e      st;
        logic [IO_W-1:0]   addr;
        logic [DATA_W-1:0] wdata;
        logic              we;
        xfer_size_e        size;
        logic              rsp_v;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t q_q, q_d;

    logic              in_win;
    logic [IO_W-1:0]   map_addr;
    logic [DATA_W-1:0] wr_swapped;
    logic [DATA_W-1:0] rd_swapped;

    io_addr_map #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS),
        .IO_W(IO_W), .PORT_BITS(PORT_BITS), .PAGE_LSB(PAGE_LSB)
    ) i_map (
        .addr(cpu_addr), .sparse(sparse_mode), .in_win(in_win), .io_addr(map_addr)
    );

    io_lane_swap #(.DATA_W(DATA_W)) i_wswap (
        .din(cpu_wdata), .size(xfer_size_e'(cpu_size)), .dout(wr_swapped)
    );

    io_lane_swap #(.DATA_W(DATA_W)) i_rswap (
        .din(io_rdata), .size(q_q.size), .dout(rd_swapped)
    );

    always_comb begin
        q_d           = q_q;
        q_d.rsp_v     = 1'b0;
        cpu_req_ready = 1'b0;
        unique case (q_q.st)
            ST_IDLE: begin
                if (cpu_req_valid && in_win) begin
                    cpu_req_ready = 1'b1;
                    q_d.st        = ST_ISSUE;
                    q_d.addr      = map_addr;
                    q_d.wdata     = wr_swapped;
                    q_d.we        = cpu_we;
                    q_d.size      = xfer_size_e'(cpu_size);
                end
            end
            ST_ISSUE: begin
                if (io_req_ready) begin
                    q_d.st = q_q.we ? ST_IDLE : ST_RDW;
                end
            end
            ST_RDW: begin
                if (io_rsp_valid) begin
                    q_d.rsp_v = 1'b1;
                    q_d.rdata = rd_swapped;
                    q_d.st    = ST_IDLE;
                end
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign io_req_valid  = (q_q.st == ST_ISSUE);
    assign io_addr       = q_q.addr;
    assign io_we         = q_q.we;
    assign io_size       = q_q.size;
    assign io_wdata      = q_q.wdata;
    assign cpu_rsp_valid = q_q.rsp_v;
    assign cpu_rdata     = q_q.rdata;
endmodule

// File: rtl/io_window_xlate_chk.sv
module io_window_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sparse_mode,
    input logic        cpu_req_valid,
    input logic        cpu_req_ready,
    input logic [31:0] cpu_addr,
    input logic [1:0]  cpu_size,
    input logic [31:0] cpu_wdata,
    input logic        cpu_rsp_valid,
    input logic        io_req_valid,
    input logic        io_req_ready,
    input logic [15:0] io_addr,
    input logic        io_we,
    input logic [1:0]  io_size,
    input logic [31:0] io_wdata,
    input logic        io_rsp_valid
);
    // R1
    out_of_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_addr[31:23] != 9'h100 && !io_req_valid) |=> !io_req_valid);

    // R2
    contig_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_ready && !sparse_mode) |=> (io_addr == $past(cpu_addr[15:0])));

    // R3
    sparse_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_ready && sparse_mode) |=>
        (io_addr == {$past(cpu_addr[22:12]), $past(cpu_addr[4:0])}));

    // R6
    word_reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_ready && cpu_size == 2'd2) |=>
        (io_wdata == {$past(cpu_wdata[7:0]), $past(cpu_wdata[15:8]),
                      $past(cpu_wdata[23:16]), $past(cpu_wdata[31:24])}));

    // R7
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req_valid && !io_req_ready) |=>
        (io_req_valid && $stable(io_addr) && $stable(io_wdata) &&
         $stable(io_we) && $stable(io_size)));

    // R7
    busy_no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_req_valid |-> !cpu_req_ready);

    // R8
    rsp_follows_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> $past(io_rsp_valid));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid);

    // R10
    write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req_valid && io_req_ready && io_we) |=> (!io_req_valid && !cpu_rsp_valid));
endmodule

bind io_window_xlate io_window_xlate_chk i_chk (
    .clk(clk), .rst_n(rst_n), .sparse_mode(sparse_mode),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .io_req_valid(io_req_valid),
    .io_req_ready(io_req_ready), .io_addr(io_addr), .io_we(io_we),
    .io_size(io_size), .io_wdata(io_wdata), .io_rsp_valid(io_rsp_valid)
);

// File: tb/test_io_window_xlate.sv
module test_io_window_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sparse_mode = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rdata;
    logic        io_req_valid;
    logic        io_req_ready = 1'b0;
    logic [15:0] io_addr;
    logic        io_we;
    logic [1:0]  io_size;
    logic [31:0] io_wdata;
    logic        io_rsp_valid = 1'b0;
    logic [31:0] io_rdata = '0;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    io_window_xlate i_io_window_xlate (.*);

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        we;
        logic        mode;
        logic [31:0] data;    // write data or returned I/O read data
        logic [15:0] exp_addr;
        logic [31:0] exp_data; // expected io_wdata or cpu_rdata
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'h8000_1234, 2'd0, 1'b1, 1'b0, 32'hA1B2_C3D4, 16'h1234, 32'hA1B2_C3D4},
        '{32'h8012_ABCD, 2'd1, 1'b1, 1'b0, 32'h1122_3344, 16'hABCD, 32'h0000_4433},
        '{32'h8000_0070, 2'd2, 1'b1, 1'b0, 32'h0102_0304, 16'h0070, 32'h0403_0201},
        '{32'h8007_F01F, 2'd2, 1'b0, 1'b1, 32'hDEAD_BEEF, 16'h0FFF, 32'hEFBE_ADDE},
        '{32'h807F_F3E5, 2'd1, 1'b0, 1'b1, 32'h5555_CAFE, 16'hFFE5, 32'h0000_FECA},
        '{32'h8040_0123, 2'd0, 1'b0, 1'b1, 32'h1234_56A5, 16'h8003, 32'h1234_56A5},
        '{32'h8000_0000, 2'd3, 1'b1, 1'b0, 32'hAABB_CCDD, 16'h0000, 32'hDDCC_BBAA},
        '{32'h807F_FFFF, 2'd0, 1'b1, 1'b0, 32'h0000_005A, 16'hFFFF, 32'h0000_005A}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string size_req(input logic [1:0] s);
        if (s == 2'd0) return "R4";
        if (s == 2'd1) return "R5";
        return "R6";
    endfunction

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_addr = v.addr; cpu_size = v.size;
        cpu_we = v.we; cpu_wdata = v.data; sparse_mode = v.mode;
        #1 check(cpu_req_ready == 1'b1, "R1 claim", 32'(cpu_req_ready), 32'd1);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        check(io_req_valid == 1'b1, "R7 issue", 32'(io_req_valid), 32'd1);
        check(io_addr == v.exp_addr, v.mode ? "R3 sparse" : "R2 contig",
              32'(io_addr), 32'(v.exp_addr));
        check(io_we == v.we && io_size == v.size, "R7 fields",
              {29'd0, io_we, io_size}, {29'd0, v.we, v.size});
        if (v.we) check(io_wdata == v.exp_data, size_req(v.size), io_wdata, v.exp_data);
        io_req_ready = 1'b1;
        @(negedge clk);
        io_req_ready = 1'b0;
        check(io_req_valid == 1'b0, "R7 accepted", 32'(io_req_valid), 32'd0);
        if (!v.we) begin
            io_rsp_valid = 1'b1; io_rdata = v.data;
            check(cpu_rsp_valid == 1'b0, "R8 early", 32'(cpu_rsp_valid), 32'd0);
        end
        @(negedge clk);
        io_rsp_valid = 1'b0;
        if (!v.we) begin
            check(cpu_rsp_valid == 1'b1, "R8 rsp", 32'(cpu_rsp_valid), 32'd1);
            check(cpu_rdata == v.exp_data, size_req(v.size), cpu_rdata, v.exp_data);
            @(negedge clk);
            check(cpu_rsp_valid == 1'b0, "R8 pulse", 32'(cpu_rsp_valid), 32'd0);
        end else begin
            check(cpu_rsp_valid == 1'b0, "R10 no rsp", 32'(cpu_rsp_valid), 32'd0);
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(io_req_valid == 1'b0, "R9 io_req_valid", 32'(io_req_valid), 32'd0);
        check(cpu_rsp_valid == 1'b0, "R9 cpu_rsp_valid", 32'(cpu_rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(io_req_valid == 1'b0, "R9 after release", 32'(io_req_valid), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: just above and just below the window
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_addr = 32'h8080_0000; cpu_we = 1'b1; cpu_size = 2'd0;
        #1 check(cpu_req_ready == 1'b0, "R1 above", 32'(cpu_req_ready), 32'd0);
        @(negedge clk);
        check(io_req_valid == 1'b0, "R1 above no io", 32'(io_req_valid), 32'd0);
        cpu_addr = 32'h7FFF_FFFC;
        #1 check(cpu_req_ready == 1'b0, "R1 below", 32'(cpu_req_ready), 32'd0);
        @(negedge clk);
        check(io_req_valid == 1'b0, "R1 below no io", 32'(io_req_valid), 32'd0);
        cpu_req_valid = 1'b0;

        // R7: hold under back-pressure, write, contiguous
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_addr = 32'h8000_0BEE; cpu_size = 2'd1;
        cpu_we = 1'b1; cpu_wdata = 32'h0000_1234; sparse_mode = 1'b0;
        @(negedge clk);
        cpu_addr = 32'h8000_0010;
        for (int k = 0; k < 3; k++) begin
            #1;
            check(io_req_valid == 1'b1 && io_addr == 16'h0BEE, "R7 hold",
                  {io_req_valid, 15'd0, io_addr}, {1'b1, 15'd0, 16'h0BEE});
            check(io_wdata == 32'h0000_3412, "R7 data stable", io_wdata, 32'h0000_3412);
            check(cpu_req_ready == 1'b0, "R7 busy", 32'(cpu_req_ready), 32'd0);
            @(negedge clk);
        end
        cpu_req_valid = 1'b0;
        io_req_ready = 1'b1;
        @(negedge clk);
        io_req_ready = 1'b0;
        // R10: claim possible right after write acceptance
        cpu_req_valid = 1'b1; cpu_addr = 32'h8000_0022; cpu_size = 2'd0; cpu_we = 1'b1;
        #1 check(cpu_req_ready == 1'b1, "R10 reclaim", 32'(cpu_req_ready), 32'd1);
        @(negedge clk);
        cpu_req_valid = 1'b0; io_req_ready = 1'b1;
        @(negedge clk);
        io_req_ready = 1'b0;

        // R8: return swap versus new request with other size and mode
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_addr = 32'h8000_0010; cpu_size = 2'd2;
        cpu_we = 1'b0; sparse_mode = 1'b0;
        @(negedge clk);
        cpu_req_valid = 1'b0; io_req_ready = 1'b1;
        @(negedge clk);
        io_req_ready = 1'b0;
        cpu_req_valid = 1'b1; cpu_addr = 32'h8000_3007; cpu_size = 2'd0;
        cpu_we = 1'b1; cpu_wdata = 32'h0000_0099; sparse_mode = 1'b1;
        #1 check(cpu_req_ready == 1'b0, "R7 busy during read", 32'(cpu_req_ready), 32'd0);
        io_rsp_valid = 1'b1; io_rdata = 32'h1122_3344;
        @(negedge clk);
        io_rsp_valid = 1'b0;
        check(cpu_rsp_valid == 1'b1, "R8 overlap rsp", 32'(cpu_rsp_valid), 32'd1);
        check(cpu_rdata == 32'h4433_2211, "R8 registered size", cpu_rdata, 32'h4433_2211);
        check(cpu_req_ready == 1'b1, "R1 claim after read", 32'(cpu_req_ready), 32'd1);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        check(io_addr == 16'h0067, "R3 sparse after overlap", 32'(io_addr), 32'h67);
        check(io_wdata == 32'h0000_0099, "R4 byte after overlap", io_wdata, 32'h99);
        io_req_ready = 1'b1;
        @(negedge clk);
        io_req_ready = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule